// File: doc/BRIEF.md
# RTC Update Cycle Sequencer

This block paces the once-per-second update of a real-time clock. A timebase enable pulse at 32.768 kHz drives a tick counter. The counter is controlled by a three-bit divider-control field. When it reaches the end of a second, the block issues a one-cycle update strobe that advances the time and calendar counters downstream. One cycle later it issues an update-ended pulse. A status flag rises a fixed number of ticks before each strobe, so host software knows when the time registers are about to change. While the flag is low, the host knows it has at least that long to read or write safely.

The host can set an inhibit bit to suppress updates while it loads new time values. The inhibit bit forces the status flag low at once and blocks every strobe. The tick counter keeps counting during inhibit, so releasing the bit does not disturb the phase of the second. A release that lands inside the warning window cancels that second's update, because no warning was given for it. The next update follows one second later. Divider-control code 3'b010 runs the counter. Codes 3'b110 and 3'b111 hold it in reset at the half-second point. Every other code freezes it where it stands.

Top module: `rtc_update_seq`

## Requirements
- R1: While rst_n is low, and in the first cycle after reset, uip, upd_strobe and upd_done are all 0.
- R2: When div_ctrl is 3'b110 or 3'b111, no update strobe occurs. The tick counter is reloaded so that the first strobe after a later switch to 3'b010 comes half a second of ticks after that switch.
- R3: After div_ctrl becomes 3'b010 following a hold-reset code, the first strobe is produced by the TICKS_PER_SEC/2-th tick.
- R4: While div_ctrl is 3'b010 and set_inhibit is 0, a strobe is produced by every TICKS_PER_SEC-th tick after the previous one.
- R5: uip rises in the cycle after the tick that lies exactly UIP_LEAD ticks before the tick that produces the strobe. It stays high through the strobe.
- R6: upd_done is high for exactly one cycle, in the cycle right after upd_strobe. upd_strobe is never high for two cycles in a row.
- R7: uip returns to 0 in the cycle after upd_done.
- R8: While set_inhibit is 1, uip reads 0 in the same cycle and no strobe or update-ended pulse is produced. The tick counter keeps its phase.
- R9: If set_inhibit falls while fewer than UIP_LEAD ticks remain before a strobe, that strobe is skipped and uip stays 0. The next strobe comes TICKS_PER_SEC ticks later.
- R10: Codes 3'b000, 3'b001, 3'b011, 3'b100 and 3'b101 freeze the tick counter and the uip flag. No strobe occurs while frozen, and counting resumes from the same point on return to 3'b010.
- R11: upd_strobe is only ever high while uip is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable pulse at the timebase rate |
| div_ctrl | input | 3 | Divider-control field: run, hold-reset or freeze |
| set_inhibit | input | 1 | Host inhibit bit; suppresses updates while 1 |
| uip | output | 1 | Update-in-progress status flag |
| upd_strobe | output | 1 | One-cycle strobe that advances the time counters |
| upd_done | output | 1 | One-cycle update-ended pulse |

## Verification
The hardest case to reach from the ports is an inhibit release that falls inside the warning window. The counter phase is invisible while the inhibit bit is set, because uip is forced low then. The bench therefore counts ticks from the last observed strobe. It raises the inhibit bit three ticks before the next update, holds it for two whole seconds, and releases it with three ticks left to go. It then checks that the skipped second produces no strobe and no flag, and that the following update lands exactly on schedule. A freeze inside the warning window and a hold-reset in mid-second are placed in the same way, using tick counts measured from the last strobe.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;

  typedef enum logic [1:0] {
    DIV_STOP = 2'd0,
    DIV_RUN  = 2'd1,
    DIV_HOLD = 2'd2
  } div_mode_e;

  function automatic div_mode_e decode_div(input logic [2:0] code);
    if (code == 3'b010)
      return DIV_RUN;
    else if (code[2:1] == 2'b11)
      return DIV_HOLD;
    else
      return DIV_STOP;
  endfunction

endpackage

// File: rtl/rtc_div_decode.sv
module rtc_div_decode
  import rtc_upd_pkg::*;
(
  input  logic [2:0] div_ctrl,
  input  logic       tick,
  output logic       run_tick,
  output logic       hold_rst
);

  div_mode_e mode;

  always_comb begin
    mode     = decode_div(div_ctrl);
    run_tick = (mode == DIV_RUN) && tick;
    hold_rst = (mode == DIV_HOLD);
  end

endmodule

// File: rtl/rtc_tick_counter.sv
module rtc_tick_counter #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_LEAD      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_tick,
  input  logic hold_rst,
  output logic wrap_evt,
  output logic lead_evt
);

  localparam int CNT_W = $clog2(TICKS_PER_SEC + 1);
  localparam logic [CNT_W-1:0] FULL_LOAD = CNT_W'(TICKS_PER_SEC);
  localparam logic [CNT_W-1:0] HALF_LOAD = CNT_W'(TICKS_PER_SEC / 2);
  localparam logic [CNT_W-1:0] LEAD_HIT  = CNT_W'(UIP_LEAD + 1);
  localparam logic [CNT_W-1:0] LAST_HIT  = CNT_W'(1);

  // ticks still to come before the next update, counting the one that fires it
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n || hold_rst)
      remain_q <= HALF_LOAD;
    else if (run_tick)
      remain_q <= (remain_q == LAST_HIT) ? FULL_LOAD : remain_q - LAST_HIT;
  end

  always_comb begin
    wrap_evt = run_tick && (remain_q == LAST_HIT);
    lead_evt = run_tick && (remain_q == LEAD_HIT);
  end

endmodule

// File: rtl/rtc_upd_window.sv
module rtc_upd_window (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_rst,
  input  logic set_inhibit,
  input  logic wrap_evt,
  input  logic lead_evt,
  output logic uip,
  output logic upd_strobe,
  output logic upd_done
);

  logic armed_q;
  logic flag_q;
  logic strobe_q;
  logic done_q;

  // armed: the warning for the coming update was actually shown to the host
  always_ff @(posedge clk) begin
    if (!rst_n || hold_rst || set_inhibit)
      armed_q <= 1'b0;
    else if (lead_evt)
      armed_q <= 1'b1;
    else if (wrap_evt)
      armed_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hold_rst || set_inhibit)
      flag_q <= 1'b0;
    else if (lead_evt)
      flag_q <= 1'b1;
    else if (done_q)
      flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      strobe_q <= wrap_evt && armed_q && !set_inhibit;
      done_q   <= upd_strobe;
    end
  end

  always_comb begin
    uip        = flag_q && !set_inhibit;
    upd_strobe = strobe_q && !set_inhibit;
    upd_done   = done_q;
  end

endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_LEAD      = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [2:0] div_ctrl,
  input  logic       set_inhibit,
  output logic       uip,
  output logic       upd_strobe,
  output logic       upd_done
);

  logic run_tick;
  logic hold_rst;
  logic wrap_evt;
  logic lead_evt;

  rtc_div_decode u_dec (
    .div_ctrl (div_ctrl),
    .tick     (tick),
    .run_tick (run_tick),
    .hold_rst (hold_rst)
  );

  rtc_tick_counter #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .UIP_LEAD      (UIP_LEAD)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_tick (run_tick),
    .hold_rst (hold_rst),
    .wrap_evt (wrap_evt),
    .lead_evt (lead_evt)
  );

  rtc_upd_window u_win (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_rst    (hold_rst),
    .set_inhibit (set_inhibit),
    .wrap_evt    (wrap_evt),
    .lead_evt    (lead_evt),
    .uip         (uip),
    .upd_strobe  (upd_strobe),
    .upd_done    (upd_done)
  );

endmodule

// File: rtl/rtc_update_seq_checker.sv
module rtc_update_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] div_ctrl,
  input logic       set_inhibit,
  input logic       uip,
  input logic       upd_strobe,
  input logic       upd_done
);

  assert_done_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |=> upd_done);

  assert_done_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> $past(upd_strobe));

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |=> !upd_strobe);

  assert_uip_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> !uip);

  assert_inhibit_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_inhibit |-> (!uip && !upd_strobe));

  assert_hold_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((div_ctrl[2:1] == 2'b11) && $past(div_ctrl[2:1] == 2'b11)) |-> !upd_strobe);

  assert_strobe_under_uip_R11: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |-> uip);

endmodule

bind rtc_update_seq rtc_update_seq_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .div_ctrl    (div_ctrl),
  .set_inhibit (set_inhibit),
  .uip         (uip),
  .upd_strobe  (upd_strobe),
  .upd_done    (upd_done)
);

// File: tb/rtc_update_seq_bench.sv
`timescale 1ns/1ps
module rtc_update_seq_bench;

  localparam int TPS  = 32;
  localparam int LEAD = 8;
  localparam int HALF = TPS / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] div_ctrl = 3'b000;
  logic       set_inhibit = 1'b0;
  logic       uip;
  logic       upd_strobe;
  logic       upd_done;

  always #2 clk = ~clk;

  rtc_update_seq #(.TICKS_PER_SEC(TPS), .UIP_LEAD(LEAD)) u_rtc_update_seq (
    .clk (clk), .rst_n (rst_n), .tick (tick), .div_ctrl (div_ctrl),
    .set_inhibit (set_inhibit), .uip (uip), .upd_strobe (upd_strobe),
    .upd_done (upd_done)
  );

  int tests = 0;
  int fails = 0;
  int tick_idx = 0;
  int cyc = 0;
  int strobe_cnt = 0;
  int last_strobe_tick = -1;
  int last_strobe_cyc = -100;
  int uip_rise_tick = -1;
  int done_err = 0;
  int fall_err = 0;
  int set_err = 0;
  int nouip_err = 0;
  logic prev_strobe = 1'b0;
  logic prev_uip = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1; tick_idx++;
      @(negedge clk); tick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  // output monitor, sampling 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    if (rst_n) begin
      if (upd_strobe) begin
        strobe_cnt++;
        last_strobe_tick = tick_idx;
        last_strobe_cyc  = cyc;
        if (!uip) nouip_err++;
      end
      if (upd_done != prev_strobe) done_err++;
      if (upd_strobe && prev_strobe) done_err++;
      if (!prev_uip && uip) uip_rise_tick = tick_idx;
      if (prev_uip && !uip && !set_inhibit && div_ctrl == 3'b010 &&
          cyc != last_strobe_cyc + 2) fall_err++;
      if (set_inhibit && (uip || upd_strobe || upd_done)) set_err++;
    end
    prev_strobe = upd_strobe;
    prev_uip    = uip;
  end

  initial begin
    #(200000 * 4);
    fails++; tests++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int t0, s, n0;
    logic [2:0] frz [5];
    frz[0] = 3'b000; frz[1] = 3'b001; frz[2] = 3'b011; frz[3] = 3'b100; frz[4] = 3'b101;

    repeat (4) @(negedge clk);
    chk(!uip && !upd_strobe && !upd_done, "R1 in reset", {uip, upd_strobe, upd_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!uip && !upd_strobe && !upd_done, "R1 after reset", {uip, upd_strobe, upd_done}, 0);

    // R2: hold-reset codes produce nothing
    div_ctrl = 3'b110;
    run(TPS + 8);
    div_ctrl = 3'b111;
    run(TPS + 8);
    chk(strobe_cnt == 0, "R2 no strobe in hold", strobe_cnt, 0);

    // R3: first update half a second after run code
    div_ctrl = 3'b010;
    t0 = tick_idx;
    run(HALF);
    chk(strobe_cnt == 1, "R3 first strobe count", strobe_cnt, 1);
    chk(last_strobe_tick == t0 + HALF, "R3 first strobe tick", last_strobe_tick, t0 + HALF);
    chk(uip_rise_tick == t0 + HALF - LEAD, "R5 first uip lead", uip_rise_tick, t0 + HALF - LEAD);

    // R4 and R5 over several seconds
    for (int k = 1; k <= 3; k++) begin
      run(TPS);
      chk(last_strobe_tick == t0 + HALF + k * TPS, "R4 period", last_strobe_tick, t0 + HALF + k * TPS);
      chk(uip_rise_tick == last_strobe_tick - LEAD, "R5 uip lead", uip_rise_tick, last_strobe_tick - LEAD);
    end
    chk(strobe_cnt == 4, "R4 strobe count", strobe_cnt, 4);

    // R2: hold in mid-second realigns to half a second
    run(7);
    div_ctrl = 3'b111;
    n0 = strobe_cnt;
    run(10);
    div_ctrl = 3'b010;
    t0 = tick_idx;
    run(HALF);
    chk(strobe_cnt == n0 + 1, "R2 realign count", strobe_cnt, n0 + 1);
    chk(last_strobe_tick == t0 + HALF, "R2 realign tick", last_strobe_tick, t0 + HALF);

    // R10: each freeze code holds the phase
    for (int c = 0; c < 5; c++) begin
      s = last_strobe_tick;
      run(5);
      div_ctrl = frz[c];
      n0 = strobe_cnt;
      run(40);
      chk(strobe_cnt == n0, "R10 no strobe frozen", strobe_cnt, n0);
      div_ctrl = 3'b010;
      run(TPS - 5);
      chk(last_strobe_tick == s + TPS + 40, "R10 phase kept", last_strobe_tick, s + TPS + 40);
    end

    // R10: freeze inside the warning window keeps uip
    s = last_strobe_tick;
    run(TPS - 3);
    div_ctrl = 3'b000;
    run(20);
    chk(uip == 1'b1, "R10 uip held frozen", uip, 1);
    div_ctrl = 3'b010;
    run(3);
    chk(last_strobe_tick == s + TPS + 20, "R10 resume in window", last_strobe_tick, s + TPS + 20);

    // R8: inhibit inside the window
    s = last_strobe_tick;
    run(TPS - 3);
    chk(uip == 1'b1, "R5 uip before inhibit", uip, 1);
    set_inhibit = 1'b1;
    #1;
    chk(uip == 1'b0, "R8 uip forced low", uip, 0);
    n0 = strobe_cnt;
    run(2 * TPS);
    chk(strobe_cnt == n0, "R8 no strobes", strobe_cnt, n0);

    // R9: release with 3 ticks left
    set_inhibit = 1'b0;
    run(10);
    chk(strobe_cnt == n0, "R9 skipped update", strobe_cnt, n0);
    chk(uip == 1'b0, "R9 uip low", uip, 0);
    run(TPS - 7);
    chk(strobe_cnt == n0 + 1, "R9 next count", strobe_cnt, n0 + 1);
    chk(last_strobe_tick == s + 4 * TPS, "R9 next tick", last_strobe_tick, s + 4 * TPS);
    chk(uip_rise_tick == last_strobe_tick - LEAD, "R5 after release", uip_rise_tick, last_strobe_tick - LEAD);

    run(2);
    chk(done_err == 0, "R6 done timing", done_err, 0);
    chk(fall_err == 0, "R7 uip fall timing", fall_err, 0);
    chk(set_err == 0, "R8 quiet under inhibit", set_err, 0);
    chk(nouip_err == 0, "R11 strobe under uip", nouip_err, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule